// File: doc/BRIEF.md
# Dual-Channel Biphase DSD Line Encoder

This block turns two independent one-bit DSD sample streams, left and right, into biphase line code. Each source bit is replaced by a pair of half-bits sent at twice the source bit rate. A source 0 is sent as half-bit 0 followed by half-bit 1. A source 1 is sent as half-bit 1 followed by half-bit 0. Both channels run from one system clock at twice the bit rate, so every source bit spans exactly two clock cycles.

A one-cycle `bit_start` strobe marks the first clock of each source bit. On that edge the block samples both channel inputs and loads the first half-bit. On the next edge it emits the inverse of the sample. The half-bit phase comes from this strobe and not from a free-running toggle, so the order of the two half-bits does not depend on the clock phase in which reset is released. Data never passes through a gate together with the clock. All outputs come from registers in a synchronous state machine.

Top module: `bphs_dsd_encoder`

## Requirements
- R1: On a clock edge where `bit_start` is 1, each channel samples its input. In the following cycle that channel's output carries the sampled value as the first half-bit, so the latency is one clock.
- R2: In the cycle after a first half-bit, when `bit_start` is 0 on that edge, each output carries the inverse of its stored sample. A source 0 therefore appears as 0 then 1, and a source 1 as 1 then 0. The data inputs on that edge have no effect.
- R3: The left and right channels are encoded independently, with identical latency, so all four input combinations appear correctly on the same cycles.
- R4: The half-bit order depends only on the position of `bit_start`. It does not depend on how many cycles pass between reset release and the first `bit_start`.
- R5: Until the first `bit_start` after reset, both outputs are 0, and `out_valid` and `phase_error` are 0. `out_valid` rises in the cycle the first half-bit appears and stays high until reset.
- R6: If `bit_start` is absent on the edge after a second half-bit, both outputs hold their last value until the next `bit_start`.
- R7: If `bit_start` is 1 on an edge that should produce a second half-bit, the block resynchronises to it: it loads the new samples as first half-bits and raises `phase_error` for exactly that output cycle. In every other cycle `phase_error` is 0.
- R8: Reset is synchronous and active high. In the cycle after a reset edge, both outputs, `out_valid` and `phase_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the source bit rate |
| rst | input | 1 | Synchronous reset, active high |
| bit_start | input | 1 | High for one clock at the first half of each source bit |
| din_left | input | 1 | Left channel DSD sample |
| din_right | input | 1 | Right channel DSD sample |
| half_left | output | 1 | Left channel biphase half-bit |
| half_right | output | 1 | Right channel biphase half-bit |
| out_valid | output | 1 | High from the first encoded half-bit onward |
| phase_error | output | 1 | One-cycle flag for a `bit_start` that arrives in the second-half slot |

## Verification
The bench builds the block with its default of two lanes. That leaves only four sample pairs per source bit, so every sequence of four consecutive stereo bits (256 sequences) can be swept, and each sequence reaches every transition between adjacent bits on both lanes. The small state space also allows the delay from reset release to the first strobe to be swept over several odd and even counts. It also allows strobes to be dropped and to be placed in the second-half slot, including several in a row.

// File: rtl/bphs_pkg.sv
package bphs_pkg;

  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  localparam int unsigned IDX_LEFT = 0;
  localparam int unsigned IDX_RIGHT = 1;

  typedef logic [LANES-1:0] lane_vec_t;

  // Half-bit for a stored sample: the sample itself in the first slot,
  // its complement in the second slot.
  function automatic logic half_bit(input logic sample, input logic second_slot);
    return second_slot ? ~sample : sample;
  endfunction

endpackage

// File: rtl/bphs_phase_track.sv
module bphs_phase_track (
  input  logic clk,
  input  logic rst,
  input  logic bit_start,
  output logic load_evt,
  output logic second_evt,
  output logic misphase_evt,
  output logic started,
  output logic phase_err
);

  logic expect_second;

  // Events on the present edge, decided from the registered phase
  assign load_evt     = bit_start;
  assign second_evt   = expect_second & ~bit_start;
  assign misphase_evt = expect_second & bit_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_second <= 1'b0;
      started       <= 1'b0;
      phase_err     <= 1'b0;
    end else begin
      expect_second <= bit_start;
      started       <= started | bit_start;
      phase_err     <= misphase_evt;
    end
  end

endmodule

// File: rtl/bphs_lane.sv
module bphs_lane
  import bphs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_evt,
  input  logic second_evt,
  input  logic din,
  output logic half
);

  logic sample_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= 1'b0;
      half     <= 1'b0;
    end else if (load_evt) begin
      sample_q <= din;
      half     <= half_bit(din, 1'b0);
    end else if (second_evt) begin
      half     <= half_bit(sample_q, 1'b1);
    end
  end

endmodule

// File: rtl/bphs_dsd_encoder.sv
module bphs_dsd_encoder
  import bphs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_start,
  input  logic din_left,
  input  logic din_right,
  output logic half_left,
  output logic half_right,
  output logic out_valid,
  output logic phase_error
);

  logic      load_evt;
  logic      second_evt;
  logic      misphase_evt;
  logic      started;
  logic      phase_err;
  lane_vec_t din_vec;
  lane_vec_t half_vec;

  assign din_vec[IDX_LEFT]  = din_left;
  assign din_vec[IDX_RIGHT] = din_right;

  bphs_phase_track track_i (
    .clk          (clk),
    .rst          (rst),
    .bit_start    (bit_start),
    .load_evt     (load_evt),
    .second_evt   (second_evt),
    .misphase_evt (misphase_evt),
    .started      (started),
    .phase_err    (phase_err)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bphs_lane lane_i (
      .clk        (clk),
      .rst        (rst),
      .load_evt   (load_evt),
      .second_evt (second_evt),
      .din        (din_vec[g]),
      .half       (half_vec[g])
    );
  end

  assign half_left   = half_vec[IDX_LEFT];
  assign half_right  = half_vec[IDX_RIGHT];
  assign out_valid   = started;
  assign phase_error = phase_err;

endmodule

// File: rtl/bphs_dsd_encoder_chk.sv
module bphs_dsd_encoder_chk (
  input logic clk,
  input logic rst,
  input logic bit_start,
  input logic din_left,
  input logic din_right,
  input logic half_left,
  input logic half_right,
  input logic out_valid,
  input logic phase_error,
  input logic second_evt,
  input logic misphase_evt
);

  // R1: a strobe edge puts the sampled inputs on the outputs one clock later
  p_first_half_r1: assert property (@(posedge clk) disable iff (rst)
    bit_start |=> (half_left == $past(din_left)) && (half_right == $past(din_right)));

  // R2: a second-half slot inverts both outputs
  p_second_half_r2: assert property (@(posedge clk) disable iff (rst)
    second_evt |=> (half_left != $past(half_left)) && (half_right != $past(half_right)));

  // R5: quiet outputs before the first strobe
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!half_left && !half_right && !phase_error));

  // R5: out_valid stays high once set
  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R6: with no strobe and no second-half slot, the outputs hold
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!bit_start && !second_evt) |=> ($stable(half_left) && $stable(half_right)));

  // R7: the error flag follows exactly the misplaced strobes
  p_misphase_flag_r7: assert property (@(posedge clk) disable iff (rst)
    misphase_evt |=> phase_error);

  p_misphase_cause_r7: assert property (@(posedge clk) disable iff (rst)
    !misphase_evt |=> !phase_error);

  // R8: a reset edge clears every output
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!half_left && !half_right && !out_valid && !phase_error));

endmodule

bind bphs_dsd_encoder bphs_dsd_encoder_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .bit_start    (bit_start),
  .din_left     (din_left),
  .din_right    (din_right),
  .half_left    (half_left),
  .half_right   (half_right),
  .out_valid    (out_valid),
  .phase_error  (phase_error),
  .second_evt   (second_evt),
  .misphase_evt (misphase_evt)
);

// File: tb/bphs_dsd_encoder_tb.sv
module bphs_dsd_encoder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_start = 1'b0;
  logic din_left = 1'b0;
  logic din_right = 1'b0;
  logic half_left, half_right, out_valid, phase_error;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference state built from the requirements
  bit   m_started;
  int   m_since_load;
  bit   m_left, m_right;
  bit   m_out_l, m_out_r;
  bit   m_perr;

  always #2 clk = ~clk;

  bphs_dsd_encoder dut_i (
    .clk         (clk),
    .rst         (rst),
    .bit_start   (bit_start),
    .din_left    (din_left),
    .din_right   (din_right),
    .half_left   (half_left),
    .half_right  (half_right),
    .out_valid   (out_valid),
    .phase_error (phase_error)
  );

  task automatic cmp(input logic act, input logic exp, input string tag, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(half_left, m_out_l, tag, "half_left");
    cmp(half_right, m_out_r, tag, "half_right");
    cmp(out_valid, m_started, tag, "out_valid");
    cmp(phase_error, m_perr, tag, "phase_error");
  endtask

  task automatic model_reset();
    m_started    = 1'b0;
    m_since_load = 100;
    m_left       = 1'b0;
    m_right      = 1'b0;
    m_out_l      = 1'b0;
    m_out_r      = 1'b0;
    m_perr       = 1'b0;
  endtask

  // R8: reset for two edges, then look at every output
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_start = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    model_reset();
    check_all("R8");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One clock: drive at the falling edge, check 1 ns after the rising edge
  task automatic step(input logic bs, input logic l, input logic r, input string tag);
    @(negedge clk);
    bit_start = bs;
    din_left  = l;
    din_right = r;
    @(posedge clk);
    #1;
    if (bs) begin
      m_perr       = (m_since_load == 0);
      m_since_load = 0;
      m_left       = l;
      m_right      = r;
      m_out_l      = l;
      m_out_r      = r;
      m_started    = 1'b1;
    end else begin
      m_perr = 1'b0;
      if (m_since_load < 100) m_since_load++;
      if (m_since_load == 1) begin
        m_out_l = !m_left;
        m_out_r = !m_right;
      end
    end
    check_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();

    // R5: idle before the first strobe, with data toggling on the inputs
    for (int i = 0; i < 5; i++) step(1'b0, i[0], ~i[0], "R5");

    // R1 R2 R3: every sequence of four stereo bits
    for (int s = 0; s < 256; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic l, r;
        l = s[2*k];
        r = s[2*k+1];
        step(1'b1, l, r, "R1");
        step(1'b0, ~l, ~r, "R2");
      end
    end
    step(1'b1, 1'b0, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, "R3");

    // R6: missing strobes hold the outputs
    for (int i = 0; i < 4; i++) step(1'b0, i[1], i[0], "R6");
    step(1'b1, 1'b1, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b1, "R6");

    // R7: strobe in the second-half slot, single and repeated
    step(1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");

    // R4: reset released a variable number of cycles before the first strobe
    for (int d = 0; d < 6; d++) begin
      do_reset();
      for (int i = 0; i < d; i++) step(1'b0, 1'b1, 1'b1, "R4");
      for (int b = 0; b < 4; b++) begin
        step(1'b1, b[0], b[1], "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
      end
    end

    // R8: reset in the middle of a bit
    step(1'b1, 1'b1, 1'b1, "R8");
    do_reset();
    step(1'b0, 1'b1, 1'b1, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule